// File: doc/BRIEF.md
# Dual-Clock Ancillary Word Buffer with Fill Status

This block is a single-channel buffer for ancillary words. A producer loads 10-bit words on its own write clock; the video side removes them, one per video clock, on a separate read clock. Both enables are active low. An active-low synchronous flush puts both pointers back at their starting location. No other reset exists.

The two pointers cross between the clock domains in Gray code through two-flop synchronizers. Each side then works out the fill level from its own pointer and the synchronized pointer of the other side. A 3-bit status code reports one of eight conditions. The write side owns the upper fill codes and the overrun code. The read side owns the lower fill codes and the underrun code. Each side's code lags the operation that caused it by three of its own clock edges.

An error code stays set until a later operation in the same domain succeeds, or until a flush. A status enable input, active low, replaces the code with a neutral value when it is high.

Top module: `anc_fifo_status`

## Requirements
- R1: Words leave `rd_data` in the order they were accepted, 10 bits each, and the buffer holds exactly 1024 words.
- R2: A write happens on a rising `wr_clk` edge when `wr_en_n` is low. When `wr_en_n` is high, no word is stored and the write pointer holds.
- R3: A read happens on a rising `rd_clk` edge when `rd_en_n` is low and the buffer is not empty. The word appears on `rd_data`, with `rd_valid` high, after that edge. When `rd_en_n` is high, `rd_valid` stays low and the read pointer holds.
- R4: While `flush_n` is low at a clock edge, that domain's pointer returns to zero and its error flag clears. After the flush the code is 001 and no stored word can be read.
- R5: The read domain reports 001 at a fill of 0 and 010 at a fill of 1 to 32. A fill of 33 to 511 gives 011.
- R6: The write domain reports 100 at a fill of 512 to 991, 101 at 992 to 1023, and 110 at 1024.
- R7: A write attempted at a fill of 1024 is dropped and sets code 111. The code holds until a write is accepted or a flush.
- R8: A read attempted at a fill of 0 gives no word (`rd_valid` low) and sets code 000. The code holds until a read succeeds or a flush.
- R9: A change in status shows on `stat_code` after the third rising edge of the owning clock, counting the edge that sampled the operation.
- R10: While `stat_oe_n` is high, `stat_code` is 011.
- R11: When both domains report, 111 takes precedence over 000. 000 takes precedence over the write-domain fill codes, and those take precedence over the read-domain fill codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 10 | Word to store |
| rd_clk | input | 1 | Video (read-side) clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 10 | Word read out |
| rd_valid | output | 1 | High for the cycle after a successful read |
| flush_n | input | 1 | Synchronous flush, active low, sampled in both domains |
| stat_oe_n | input | 1 | Status enable, active low |
| stat_code | output | 3 | Fill or error status code |

## Verification
The bench starts from empty and fills the buffer through every threshold: 1 and 32 words, 33 words, 511 and 512 words, 991 and 992 words, 1023 words and 1024 words. This shows that each boundary lands on the correct side. The three-edge latency is sampled edge by edge on both clocks, once for a read that empties the buffer and once for a write that reaches half full.

The error cases cover a write into a full buffer and a read from an empty one. The bench then checks that each error code is still set after an operation in the other domain, and that a successful operation in the same domain clears it. A full drain compares every word against its write order, which also shows that the dropped word never appears. Idle-enable, status-enable and flush patterns complete the set.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;

    typedef enum logic [2:0] {
        ST_UNDER  = 3'b000,
        ST_EMPTY  = 3'b001,
        ST_AEMPTY = 3'b010,
        ST_READY  = 3'b011,
        ST_HALF   = 3'b100,
        ST_AFULL  = 3'b101,
        ST_FULL   = 3'b110,
        ST_OVER   = 3'b111
    } stat_e;

    // Write side reports ST_READY when it has nothing to say.
    function automatic stat_e merge_codes(stat_e wcode, stat_e rcode);
        if (wcode == ST_OVER)  return ST_OVER;
        if (rcode == ST_UNDER) return ST_UNDER;
        if (wcode != ST_READY) return wcode;
        return rcode;
    endfunction

endpackage

// File: rtl/anc_fifo_ram.sv
module anc_fifo_ram #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/anc_fifo_ptr_sync.sv
module anc_fifo_ptr_sync #(
    parameter int PTR_W = 11
) (
    input  logic             dst_clk,
    input  logic             flush_n,
    input  logic [PTR_W-1:0] src_gray,
    output logic [PTR_W-1:0] dst_bin
);
    logic [PTR_W-1:0] meta_q, sync_q;

    always_ff @(posedge dst_clk) begin
        if (!flush_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray;
            sync_q <= meta_q;
        end
    end

    for (genvar i = 0; i < PTR_W; i++) begin : g_g2b
        assign dst_bin[i] = ^sync_q[PTR_W-1:i];
    end
endmodule

// File: rtl/anc_fifo_wr_ctrl.sv
module anc_fifo_wr_ctrl
    import anc_fifo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int GAP    = 32
) (
    input  logic            wr_clk,
    input  logic            flush_n,
    input  logic            wr_en_n,
    input  logic [ADDR_W:0] rd_bin_sync,
    output logic            wr_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0] wr_gray,
    output stat_e           wr_code
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] LVL_FULL  = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LVL_AFULL = PTR_W'(DEPTH - GAP);
    localparam logic [PTR_W-1:0] LVL_HALF  = PTR_W'(DEPTH / 2);

    logic [PTR_W-1:0] wptr, wptr_nxt, fill;
    logic             full, acc, bad, over_q;
    stat_e            lvl, s1_q, s2_q;

    assign fill     = wptr - rd_bin_sync;
    assign full     = (fill == LVL_FULL);
    assign acc      = !wr_en_n && !full;
    assign bad      = !wr_en_n && full;
    assign wptr_nxt = wptr + PTR_W'(1);

    always_comb begin
        if (fill == LVL_FULL)      lvl = ST_FULL;
        else if (fill >= LVL_AFULL) lvl = ST_AFULL;
        else if (fill >= LVL_HALF)  lvl = ST_HALF;
        else                        lvl = ST_READY;
    end

    always_ff @(posedge wr_clk) begin
        if (!flush_n) begin
            wptr    <= '0;
            wr_gray <= '0;
            over_q  <= 1'b0;
            s1_q    <= ST_READY;
            s2_q    <= ST_READY;
        end else begin
            if (acc) begin
                wptr    <= wptr_nxt;
                wr_gray <= (wptr_nxt >> 1) ^ wptr_nxt;
            end
            if (bad)      over_q <= 1'b1;
            else if (acc) over_q <= 1'b0;
            s1_q <= over_q ? ST_OVER : lvl;
            s2_q <= s1_q;
        end
    end

    assign wr_we   = acc;
    assign wr_addr = wptr[ADDR_W-1:0];
    assign wr_code = s2_q;

    // R1
    wr_fill_bound_chk: assert property (@(posedge wr_clk) disable iff (!flush_n)
        fill <= LVL_FULL);
    // R1
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!flush_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
    // R2
    wr_ptr_hold_chk: assert property (@(posedge wr_clk) disable iff (!flush_n)
        wr_en_n |=> $stable(wptr));
    // R7
    wr_over_hold_chk: assert property (@(posedge wr_clk) disable iff (!flush_n)
        (over_q && wr_en_n) |=> over_q);
    // R9
    wr_over_lag_chk: assert property (@(posedge wr_clk) disable iff (!flush_n)
        (s2_q == ST_OVER) |-> $past(over_q, 2));
endmodule

// File: rtl/anc_fifo_rd_ctrl.sv
module anc_fifo_rd_ctrl
    import anc_fifo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int GAP    = 32
) (
    input  logic              rd_clk,
    input  logic              flush_n,
    input  logic              rd_en_n,
    input  logic [ADDR_W:0]   wr_bin_sync,
    output logic              rd_re,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              rd_valid,
    output stat_e             rd_code
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] LVL_TOP = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LVL_AE  = PTR_W'(GAP);

    logic [PTR_W-1:0] rptr, rptr_nxt, fill;
    logic             empty, acc, bad, under_q;
    stat_e            lvl, s1_q, s2_q;

    assign fill     = wr_bin_sync - rptr;
    assign empty    = (fill == '0);
    assign acc      = !rd_en_n && !empty;
    assign bad      = !rd_en_n && empty;
    assign rptr_nxt = rptr + PTR_W'(1);

    always_comb begin
        if (fill == '0)          lvl = ST_EMPTY;
        else if (fill <= LVL_AE) lvl = ST_AEMPTY;
        else                     lvl = ST_READY;
    end

    always_ff @(posedge rd_clk) begin
        if (!flush_n) begin
            rptr     <= '0;
            rd_gray  <= '0;
            under_q  <= 1'b0;
            rd_valid <= 1'b0;
            s1_q     <= ST_EMPTY;
            s2_q     <= ST_EMPTY;
        end else begin
            if (acc) begin
                rptr    <= rptr_nxt;
                rd_gray <= (rptr_nxt >> 1) ^ rptr_nxt;
            end
            rd_valid <= acc;
            if (bad)      under_q <= 1'b1;
            else if (acc) under_q <= 1'b0;
            s1_q <= under_q ? ST_UNDER : lvl;
            s2_q <= s1_q;
        end
    end

    assign rd_re   = acc;
    assign rd_addr = rptr[ADDR_W-1:0];
    assign rd_code = s2_q;

    // R5
    rd_fill_bound_chk: assert property (@(posedge rd_clk) disable iff (!flush_n)
        fill <= LVL_TOP);
    // R3
    rd_ptr_hold_chk: assert property (@(posedge rd_clk) disable iff (!flush_n)
        rd_en_n |=> ($stable(rptr) && !rd_valid));
    // R8
    rd_under_hold_chk: assert property (@(posedge rd_clk) disable iff (!flush_n)
        (under_q && rd_en_n) |=> under_q);
    // R9
    rd_under_lag_chk: assert property (@(posedge rd_clk) disable iff (!flush_n)
        (s2_q == ST_UNDER) |-> $past(under_q, 2));
endmodule

// File: rtl/anc_fifo_status.sv
module anc_fifo_status
    import anc_fifo_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 10,
    parameter int GAP    = 32
) (
    input  logic              wr_clk,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              flush_n,
    input  logic              stat_oe_n,
    output logic [2:0]        stat_code
);
    localparam int PTR_W = ADDR_W + 1;

    logic              we, re;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wbin_at_rd, rbin_at_wr;
    stat_e             wcode, rcode, merged;

    anc_fifo_wr_ctrl #(.ADDR_W(ADDR_W), .GAP(GAP)) u_wr (
        .wr_clk(wr_clk), .flush_n(flush_n), .wr_en_n(wr_en_n),
        .rd_bin_sync(rbin_at_wr), .wr_we(we), .wr_addr(waddr),
        .wr_gray(wgray), .wr_code(wcode)
    );

    anc_fifo_rd_ctrl #(.ADDR_W(ADDR_W), .GAP(GAP)) u_rd (
        .rd_clk(rd_clk), .flush_n(flush_n), .rd_en_n(rd_en_n),
        .wr_bin_sync(wbin_at_rd), .rd_re(re), .rd_addr(raddr),
        .rd_gray(rgray), .rd_valid(rd_valid), .rd_code(rcode)
    );

    anc_fifo_ptr_sync #(.PTR_W(PTR_W)) u_w2r (
        .dst_clk(rd_clk), .flush_n(flush_n), .src_gray(wgray), .dst_bin(wbin_at_rd)
    );

    anc_fifo_ptr_sync #(.PTR_W(PTR_W)) u_r2w (
        .dst_clk(wr_clk), .flush_n(flush_n), .src_gray(rgray), .dst_bin(rbin_at_wr)
    );

    anc_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data)
    );

    assign merged    = merge_codes(wcode, rcode);
    assign stat_code = stat_oe_n ? ST_READY : merged;
endmodule

// File: tb/anc_fifo_status_tb_top.sv
module anc_fifo_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR_PERIOD  = CLK_PERIOD + 4;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_en_n = 1'b1, rd_en_n = 1'b1, flush_n = 1'b0, stat_oe_n = 1'b0;
    logic [9:0] wr_data = '0;
    logic [9:0] rd_data;
    logic       rd_valid;
    logic [2:0] stat_code;

    int n_chk = 0, n_fail = 0;
    int exp_mem [0:4095];
    int wi = 0, ri = 0;

    always #(CLK_PERIOD/2) rd_clk = ~rd_clk;
    always #(WR_PERIOD/2)  wr_clk = ~wr_clk;

    anc_fifo_status dut_i (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .flush_n(flush_n), .stat_oe_n(stat_oe_n), .stat_code(stat_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_code(input string req, input int exp);
        chk(int'(stat_code) == exp, req, int'(stat_code), exp);
    endtask

    function automatic logic [9:0] pat(input int k);
        return 10'((k * 37 + 5) & 10'h3ff);
    endfunction

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic push_burst(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge wr_clk);
            wr_en_n = 1'b0;
            wr_data = pat(wi);
            exp_mem[wi] = int'(pat(wi));
            wi++;
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic drain(input int n, input string req);
        int bad = 0, first_act = 0, first_exp = 0;
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge rd_clk);
            if (k == n - 1) rd_en_n = 1'b1;
            if (!rd_valid || int'(rd_data) != exp_mem[ri]) begin
                if (bad == 0) begin first_act = int'(rd_data); first_exp = exp_mem[ri]; end
                bad++;
            end
            ri++;
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic do_flush();
        @(negedge rd_clk);
        flush_n = 1'b0;
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
        flush_n = 1'b1;
        wi = 0; ri = 0;
        settle();
    endtask

    task automatic t_reset();
        do_flush();
        chk_code("R4 code after flush", 1);
        chk(rd_valid == 1'b0, "R4 rd_valid after flush", int'(rd_valid), 0);
    endtask

    task automatic t_stat_enable();
        stat_oe_n = 1'b1;
        #1;
        chk_code("R10 disabled status", 3);
        stat_oe_n = 1'b0;
        #1;
        chk_code("R10 re-enabled status", 1);
    endtask

    task automatic t_underrun();
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk(rd_valid == 1'b0, "R8 no word on empty read", int'(rd_valid), 0);
        settle();
        chk_code("R8 underrun code", 0);
        push_burst(1);
        settle();
        chk_code("R8 underrun sticky over write", 0);
        drain(1, "R3 word after underrun");
        settle();
        chk_code("R8 cleared by good read", 1);
    endtask

    task automatic t_enables_idle();
        int stray = 0;
        push_burst(1);
        for (int k = 0; k < 8; k++) begin
            @(negedge wr_clk);
            wr_data = 10'h2aa ^ 10'(k);
        end
        push_burst(1);
        for (int k = 0; k < 10; k++) begin
            @(negedge rd_clk);
            if (rd_valid) stray++;
        end
        chk(stray == 0, "R3 rd_valid while idle", stray, 0);
        settle();
        chk_code("R5 fill 2 code", 2);
        drain(2, "R2 only enabled words stored");
        settle();
        chk_code("R2 nothing extra stored", 1);
    endtask

    task automatic t_rd_latency();
        push_burst(1);
        settle();
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        ri++;
        chk_code("R9 read edge 1", 2);
        @(negedge rd_clk);
        chk_code("R9 read edge 2", 2);
        @(negedge rd_clk);
        chk_code("R9 read edge 3", 1);
    endtask

    task automatic t_fill();
        push_burst(32);
        settle();
        chk_code("R5 fill 32", 2);
        push_burst(1);
        settle();
        chk_code("R5 fill 33", 3);
        push_burst(478);
        settle();
        chk_code("R5 fill 511", 3);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        wr_data = pat(wi);
        exp_mem[wi] = int'(pat(wi));
        wi++;
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        chk_code("R9 write edge 1", 3);
        @(negedge wr_clk);
        chk_code("R9 write edge 2", 3);
        @(negedge wr_clk);
        chk_code("R9 write edge 3 half", 4);
        push_burst(479);
        settle();
        chk_code("R6 fill 991", 4);
        push_burst(1);
        settle();
        chk_code("R6 fill 992", 5);
        push_burst(31);
        settle();
        chk_code("R6 fill 1023", 5);
        push_burst(1);
        settle();
        chk_code("R6 fill 1024", 6);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        wr_data = 10'h3c3;
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        settle();
        chk_code("R7 overrun code", 7);
        drain(1, "R1 first word out");
        settle();
        chk_code("R11 overrun sticky after read", 7);
        push_burst(1);
        settle();
        chk_code("R7 cleared by good write", 6);
        drain(1024, "R1 order of 1024 words");
        settle();
        chk_code("R5 empty after drain", 1);
    endtask

    task automatic t_flush_mid();
        push_burst(5);
        settle();
        do_flush();
        chk_code("R4 code after flush with data", 1);
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk(rd_valid == 1'b0, "R4 no stale word after flush", int'(rd_valid), 0);
        do_flush();
    endtask

    initial begin
        t_reset();
        t_stat_enable();
        t_underrun();
        t_enables_idle();
        t_rd_latency();
        t_fill();
        t_flush_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule